// File: doc/BRIEF.md
# Two-Wire Configuration Register Target with Staged Commit

This block is a two-wire (I2C) target that owns a bank of 34 eight-bit configuration registers. It oversamples SCL and SDA with the system clock, detects start and stop conditions, and decodes two transaction types. A write sends a register pointer byte and then any number of data bytes. A read sends the pointer, then a repeated start with the read bit, after which the target returns bytes until the controller withholds its acknowledge. The register pointer advances by one after every data byte in both directions.

A level on `addr_sel_i` chooses between two bus addresses. Some bit fields are staged: a write lands in a shadow copy, and the live value on `regs_o` changes only when register 0 is written. All staged fields are then copied in one cycle and `commit_o` pulses. Bits that are not staged take effect as soon as their byte has been received. The three highest registers are read-only. The last of them returns a fixed revision code.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges the 7-bit address 0x30 when `addr_sel_i` is 1 and 0x20 when it is 0, with the R/W bit in bit 0 of the first byte (0 write, 1 read). It acknowledges by pulling SDA low during the ninth SCL pulse.
- R2: An address byte that does not match is not acknowledged. SDA stays released, and no register changes until the next start condition.
- R3: In a write, the first byte after the address sets the register pointer. Each following data byte is acknowledged, stored at the pointer, and advances the pointer by one.
- R4: After a repeated start with the read bit, the target returns the byte at the pointer MSB first and advances the pointer by one per byte. A controller acknowledge (SDA low) requests the next byte. A missing acknowledge ends the read with SDA released.
- R5: Registers 31, 32 and 33, and any pointer at 34 or above, discard writes but still acknowledge them. Register 33 reads 0x5A, and the others in this range read 0x00.
- R6: Staged bits use these masks: reg0 0xFF, reg1 0xFF, reg2 0xFF, reg3 0x01, reg5 0x10, reg6 0xFF, reg7 0x0F, reg9 0xF0, reg10 0x7F; all other registers have none. A write changes no staged bit on `regs_o` unless it targets register 0. A read returns the last value written, including staged bits.
- R7: A write to register 0 copies every staged bit of every register, including the byte just written to register 0, to `regs_o`. It also raises `commit_o` for exactly one clock per write.
- R8: Unstaged bits of a writable register, for example bit 0 of register 29, appear on `regs_o` as soon as the byte has been received, without any write to register 0.
- R9: After reset, `regs_o` shows all registers as 0x00 except register 33 (0x5A). `commit_o` is 0 and SDA is released.
- R10: The target changes its SDA drive only after a falling SCL edge, or on a start or stop condition. A stop returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel_i | input | 1 | Selects bus address 0x30 (1) or 0x20 (0) |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| regs_o | output | 272 | Live register values, register k at bits [8k+7:8k] |
| commit_o | output | 1 | One-clock pulse when staged fields are committed |

## Verification
Some properties are checked on every cycle. SDA drive changes only after a falling SCL edge or a bus condition. The target is silent when idle or ignoring a transfer. Staged bits hold still unless register 0 is written. Unstaged bits follow the written byte at once. Every commit pulse comes from a register 0 write. Other behaviour is shown only by the bench scenarios, checked against its register model: address matching for both select levels, pointer auto-increment across bursts, repeated-start reads ending on a missing acknowledge, and the acknowledged but discarded writes to read-only and out-of-range pointers.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_WAIT, ST_ACK, ST_TX, ST_TX_ACK, ST_TX_NEXT, ST_IGNORE
  } fsm_e;

  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA} rx_kind_e;

  // Bits held in shadow until register 0 is written
  function automatic logic [7:0] db_mask(input int idx);
    case (idx)
      0, 1, 2, 6: db_mask = 8'hFF;
      3:          db_mask = 8'h01;
      5:          db_mask = 8'h10;
      7:          db_mask = 8'h0F;
      9:          db_mask = 8'hF0;
      10:         db_mask = 8'h7F;
      default:    db_mask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR_HI = 7'h30,
  parameter logic [6:0] ADDR_LO = 7'h20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_sel_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rdata_i,
  output logic [7:0] raddr_o,
  output logic       we_o,
  output logic [7:0] waddr_o,
  output logic [7:0] wdata_o,
  output logic       sda_oe_o
);
  fsm_e       state_q;
  rx_kind_e   kind_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] sh_q, tx_q, ptr_q;
  logic       rd_mode_q;
  logic [7:0] rx_byte;
  logic [6:0] own_addr;

  assign rx_byte  = {sh_q[6:0], sda_i};
  assign own_addr = addr_sel_i ? ADDR_HI : ADDR_LO;
  assign raddr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_ADDR;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rd_mode_q <= 1'b0;
      sda_oe_o  <= 1'b0;
      we_o      <= 1'b0;
      waddr_o   <= '0;
      wdata_o   <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_RX;
        kind_q    <= K_ADDR;
        bit_cnt_q <= '0;
        rd_mode_q <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: if (scl_rise_i) begin
            sh_q      <= rx_byte;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              state_q <= ST_ACK_WAIT;
              unique case (kind_q)
                K_ADDR: begin
                  if (rx_byte[7:1] == own_addr) begin
                    rd_mode_q <= rx_byte[0];
                    kind_q    <= K_SUB;
                  end else begin
                    state_q <= ST_IGNORE;
                  end
                end
                K_SUB: begin
                  ptr_q  <= rx_byte;
                  kind_q <= K_DATA;
                end
                default: begin
                  we_o    <= 1'b1;
                  waddr_o <= ptr_q;
                  wdata_o <= rx_byte;
                  ptr_q   <= ptr_q + 8'd1;
                end
              endcase
            end
          end
          ST_ACK_WAIT: if (scl_fall_i) begin
            sda_oe_o <= 1'b1;
            state_q  <= ST_ACK;
          end
          ST_ACK, ST_TX_NEXT: if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (rd_mode_q) begin
              tx_q     <= rdata_i;
              sda_oe_o <= ~rdata_i[7];
              ptr_q    <= ptr_q + 8'd1;
              state_q  <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (bit_cnt_q == 3'd7) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_TX_ACK;
            end else begin
              bit_cnt_q <= bit_cnt_q + 3'd1;
              tx_q      <= {tx_q[6:0], 1'b0};
              sda_oe_o  <= ~tx_q[6];
            end
          end
          ST_TX_ACK: if (scl_rise_i) begin
            state_q <= sda_i ? ST_IGNORE : ST_TX_NEXT;
          end
          default: ;
        endcase
      end
    end
  end

  // R10: drive changes only after SCL fall or a bus condition
  p_oe_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall_i || start_i || stop_i));

  // R2: an ignored transfer never drives the bus
  p_ignore_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !sda_oe_o);

  // R9: idle target neither drives nor writes
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!sda_oe_o && !we_o));

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 34,
  parameter int         RO_COUNT = 3,
  parameter logic [7:0] REVISION = 8'h5A
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [7:0]              waddr_i,
  input  logic [7:0]              wdata_i,
  input  logic [7:0]              raddr_i,
  output logic [7:0]              rdata_o,
  output logic [NUM_REGS*8-1:0]   regs_o,
  output logic                    commit_o
);
  localparam int WR_LIMIT = NUM_REGS - RO_COUNT;

  logic [7:0] shadow_q [WR_LIMIT];
  logic [7:0] active_q [WR_LIMIT];
  logic       wr_ok, commit_hit;

  assign wr_ok      = we_i && (waddr_i < 8'(WR_LIMIT));
  assign commit_hit = wr_ok && (waddr_i == 8'd0);

  for (genvar g = 0; g < WR_LIMIT; g++) begin : g_wr
    localparam logic [7:0] M = db_mask(g);
    logic       hit;
    logic [7:0] sh_nx, ac_base, ac_nx;

    always_comb begin
      hit     = wr_ok && (waddr_i == 8'(g));
      sh_nx   = hit ? wdata_i : shadow_q[g];
      ac_base = hit ? ((active_q[g] & M) | (wdata_i & ~M)) : active_q[g];
      ac_nx   = commit_hit ? ((ac_base & ~M) | (sh_nx & M)) : ac_base;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
        active_q[g] <= '0;
      end else begin
        shadow_q[g] <= sh_nx;
        active_q[g] <= ac_nx;
      end
    end

    assign regs_o[g*8 +: 8] = active_q[g];

    if (M != 8'h00) begin : g_hold
      // R6: staged bits move only on a register 0 write
      p_db_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_hit |=> ((active_q[g] & M) == $past(active_q[g] & M)));
    end
    if (M != 8'hFF) begin : g_imm
      // R8: unstaged bits follow the written byte at once
      p_imm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i == 8'(g)) |=> ((active_q[g] & ~M) == ($past(wdata_i) & ~M)));
    end
  end

  for (genvar g = WR_LIMIT; g < NUM_REGS; g++) begin : g_ro
    assign regs_o[g*8 +: 8] = (g == NUM_REGS - 1) ? REVISION : 8'h00;
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < WR_LIMIT; i++)
      if (raddr_i == 8'(i)) rdata_o = shadow_q[i];
    if (raddr_i == 8'(NUM_REGS - 1)) rdata_o = REVISION;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) commit_o <= 1'b0;
    else         commit_o <= commit_hit;
  end

  // R7: every commit pulse follows a register 0 write
  p_commit_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(we_i && waddr_i == 8'd0));

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter int         NUM_REGS = 34,
  parameter int         RO_COUNT = 3,
  parameter logic [7:0] REVISION = 8'h5A,
  parameter logic [6:0] ADDR_HI  = 7'h30,
  parameter logic [6:0] ADDR_LO  = 7'h20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  commit_o
);
  logic       sda_s, scl_rise, scl_fall, start, stop;
  logic       we;
  logic [7:0] waddr, wdata, raddr, rdata;

  i2c_bus_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_target_fsm #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_sel_i (addr_sel_i),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rdata_i    (rdata),
    .raddr_o    (raddr),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .sda_oe_o   (sda_oe_o)
  );

  cfg_regbank #(.NUM_REGS(NUM_REGS), .RO_COUNT(RO_COUNT), .REVISION(REVISION)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .waddr_i  (waddr),
    .wdata_i  (wdata),
    .raddr_i  (raddr),
    .rdata_o  (rdata),
    .regs_o   (regs_o),
    .commit_o (commit_o)
  );

endmodule

// File: tb/tb_i2c_cfg_target.sv
`timescale 1ns/1ps
module tb_i2c_cfg_target;
  localparam int         NREG = 34;
  localparam int         WRL  = 31;
  localparam logic [7:0] REV  = 8'h5A;
  localparam int         Q    = 8;

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, m_oe = 1'b0, sel = 1'b1;
  logic sda_oe, commit;
  logic [NREG*8-1:0] regs;
  wire sda_line = !(m_oe || sda_oe);

  int checks = 0, errors = 0, commits_seen = 0, commits_exp = 0;
  logic [7:0] m_shadow [WRL];
  logic [7:0] m_active [WRL];

  always #2.5 clk = ~clk;

  i2c_cfg_target dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(sel), .sda_oe_o(sda_oe), .regs_o(regs), .commit_o(commit)
  );

  always @(negedge clk) if (commit) commits_seen++;

  function automatic logic [7:0] mask_of(input int a);
    case (a)
      0, 1, 2, 6: return 8'hFF;
      3: return 8'h01;
      5: return 8'h10;
      7: return 8'h0F;
      9: return 8'hF0;
      10: return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] live_of(input int a);
    if (a < WRL) return m_active[a];
    return (a == NREG - 1) ? REV : 8'h00;
  endfunction

  function automatic logic [7:0] read_of(input int a);
    if (a < WRL) return m_shadow[a];
    return (a == NREG - 1) ? REV : 8'h00;
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    logic [7:0] m;
    if (a >= WRL) return;
    m = mask_of(a);
    m_shadow[a] = d;
    m_active[a] = (m_active[a] & m) | (d & ~m);
    if (a == 0) begin
      for (int i = 0; i < WRL; i++)
        m_active[i] = (m_active[i] & ~mask_of(i)) | (m_shadow[i] & mask_of(i));
      commits_exp++;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    int bad = -1;
    for (int k = 0; k < NREG; k++)
      if (bad < 0 && regs[k*8 +: 8] !== live_of(k)) bad = k;
    if (bad < 0) chk(1'b1, req, "regs", 0, 0);
    else chk(1'b0, req, $sformatf("reg%0d", bad), int'(regs[bad*8 +: 8]), int'(live_of(bad)));
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic rd);
    m_oe = ~b; wait_q();
    scl = 1'b1; wait_q();
    rd = sda_line; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bus_start();
    m_oe = 1'b0; wait_q();
    scl = 1'b1; wait_q();
    m_oe = 1'b1; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_oe = 1'b1; wait_q();
    scl = 1'b1; wait_q();
    m_oe = 1'b0; wait_q();
  endtask

  task automatic byte_wr(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic byte_rd(input logic m_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, r); d[i] = r; end
    bus_bit(~m_ack, r);
  endtask

  function automatic logic [6:0] own_addr();
    return sel ? 7'h30 : 7'h20;
  endfunction

  task automatic do_write(input logic [6:0] a7, input int sub, input int n,
                          input logic [7:0] d [8], input string req);
    logic ack;
    bit hit = (a7 == own_addr());
    bus_start();
    byte_wr({a7, 1'b0}, ack);
    chk(ack == hit, hit ? "R1" : "R2", "addr ack", ack, hit);
    byte_wr(8'(sub), ack);
    chk(ack == hit, req, "sub ack", ack, hit);
    for (int i = 0; i < n; i++) begin
      byte_wr(d[i], ack);
      chk(ack == hit, req, $sformatf("data ack %0d", i), ack, hit);
      if (hit) model_write((sub + i) & 255, d[i]);
    end
    bus_stop();
  endtask

  task automatic do_read(input int sub, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    byte_wr({own_addr(), 1'b0}, ack);
    byte_wr(8'(sub), ack);
    bus_start();
    byte_wr({own_addr(), 1'b1}, ack);
    chk(ack, "R1", "read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      byte_rd(i != n - 1, d);
      chk(d == read_of((sub + i) & 255), req, $sformatf("read ptr %0d", (sub + i) & 255),
          d, read_of((sub + i) & 255));
    end
    chk(sda_oe == 1'b0, "R4", "released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d [8];
    int c0;
    void'($urandom(32'd4242));
    for (int i = 0; i < WRL; i++) begin m_shadow[i] = 8'h00; m_active[i] = 8'h00; end
    for (int i = 0; i < 8; i++) d[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check_regs("R9");
    chk(commit == 1'b0 && sda_oe == 1'b0, "R9", "commit/oe", {commit, sda_oe}, 0);

    // R1 + R8: address 0x30, reg29 bit0 immediate
    d[0] = 8'h01;
    do_write(7'h30, 29, 1, d, "R8");
    check_regs("R8");

    // R1: low select answers 0x20; R2: 0x30 ignored
    sel = 1'b0;
    d[0] = 8'hC3;
    do_write(7'h20, 12, 1, d, "R1");
    check_regs("R1");
    d[0] = 8'hFF; d[1] = 8'hEE;
    do_write(7'h30, 12, 2, d, "R2");
    chk(sda_oe == 1'b0, "R2", "oe after nack", sda_oe, 0);
    check_regs("R2");
    sel = 1'b1;

    // R6: staged bits wait; reads return staged value
    d[0] = 8'h3C; d[1] = 8'h0F; d[2] = 8'h00; d[3] = 8'hA5;
    do_write(7'h30, 6, 4, d, "R3");
    check_regs("R6");
    do_read(6, 4, "R6");

    // R7: register 0 write commits all staged bits
    c0 = commits_seen;
    d[0] = 8'h77;
    do_write(7'h30, 0, 1, d, "R7");
    check_regs("R7");
    chk(commits_seen == c0 + 1, "R7", "commit pulses", commits_seen - c0, 1);

    // R5: read-only and out-of-range
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    do_write(7'h30, 31, 4, d, "R5");
    check_regs("R5");
    do_read(30, 5, "R5");
    d[0] = 8'h99;
    do_write(7'h30, 200, 1, d, "R5");
    check_regs("R5");
    do_read(254, 3, "R4");

    // R3/R4 random bursts
    for (int t = 0; t < 24; t++) begin
      int sub = $urandom_range(0, 37);
      int n = $urandom_range(1, 5);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
      if ($urandom_range(0, 3) == 0) sub = 0;
      do_write(7'h30, sub, n, d, "R3");
      check_regs("R3");
      do_read($urandom_range(0, 35), $urandom_range(1, 4), "R4");
    end
    chk(commits_seen == commits_exp, "R7", "total commits", commits_seen, commits_exp);
    chk(sda_oe == 1'b0, "R10", "idle after stop", sda_oe, 0);
    finish_run();
  end

endmodule